// File: doc/BRIEF.md
# Aliased General Register File

This block holds eight 32-bit general registers and lets each one be read or written at several widths. A full 32-bit access reaches the whole register. A 16-bit access reaches bits 15:0. On the first four registers, a byte access reaches either bits 7:0 or bits 15:8. The last four registers are the stack pointer, base pointer, source index and destination index. They accept only 16-bit and 32-bit accesses.

There are two combinational read ports and one clocked write port. Each port is addressed by a register number, a size code and a high-byte select. Read data always comes out right-aligned and zero-extended, and write data is taken right-aligned. This means an external ALU can combine the two read values and return the result through the write port. Register-to-register moves and byte add or subtract are built that way.

A narrow write changes only its own slice of the register. An access that asks for a view the register does not have raises that port's illegal flag. Such an access reads as zero and writes nothing.

Top module: `alias_regfile`

## Requirements
- R1: After reset (rstN low), every register reads 0x00000000 at 32-bit size.
- R2: Register numbers 0..7 select a, b, c, d, stack pointer, base pointer, source index and destination index in that order. Size code 2'b10 reads or writes all 32 bits.
- R3: Read results are right-aligned and zero-extended. Size 2'b01 returns bits 15:0. Size 2'b00 returns bits 7:0 when the high select is 0 and bits 15:8 when it is 1.
- R4: A byte write (size 2'b00) stores wrData[7:0] into bits 7:0, or into bits 15:8 when wrHi is 1. Every other bit of the register keeps its value.
- R5: A 16-bit write (size 2'b01) stores wrData[15:0] into bits 15:0 and keeps bits 31:16.
- R6: A 32-bit write replaces the whole register with wrData.
- R7: A port's illegal flag is 1 when it requests size 2'b11, or size 2'b00 on register 4..7. The flag is combinational, and the write flag also requires wrEn. An illegal read returns zero, and an illegal write leaves every register unchanged.
- R8: A read of a register being written in the same cycle returns the old value. The new value appears after the clock edge.
- R9: Both read ports can address any registers at once. This allows a same-size move, and a byte add or subtract through an external ALU written back via the write port.
- R10: With wrEn low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdRegA | input | 3 | Read port A register number |
| rdSizeA | input | 2 | Read port A size code |
| rdHiA | input | 1 | Read port A high-byte select |
| rdDataA | output | 32 | Read port A data, right-aligned |
| rdBadA | output | 1 | Read port A illegal-operand flag |
| rdRegB | input | 3 | Read port B register number |
| rdSizeB | input | 2 | Read port B size code |
| rdHiB | input | 1 | Read port B high-byte select |
| rdDataB | output | 32 | Read port B data, right-aligned |
| rdBadB | output | 1 | Read port B illegal-operand flag |
| wrEn | input | 1 | Write enable |
| wrReg | input | 3 | Write register number |
| wrSize | input | 2 | Write size code |
| wrHi | input | 1 | Write high-byte select |
| wrData | input | 32 | Write data, right-aligned |
| wrBad | output | 1 | Write illegal-operand flag |

## Verification
The hardest case to reach is slice preservation. A narrow write must be shown to leave distinct, known bit patterns untouched in the other lanes. So the stimulus first fills a register with a full-width value whose bytes all differ, then lays high-byte, low-byte and 16-bit writes over it, and reads it back in full each time. An illegal byte write to a pointer register is followed by a full-width read of that register, which shows the write did nothing. A write and a read of the same register are also placed in one cycle, and the read value is sampled both before and after the edge.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int DATA_W       = 32;
  localparam int REG_CNT      = 8;
  localparam int BYTE_REG_CNT = 4;
  localparam int LANES        = DATA_W / 8;
  localparam int IDX_W        = $clog2(REG_CNT);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_RSVD  = 2'b11
  } opSize_e;

  typedef struct packed {
    logic [IDX_W-1:0] regIdx;
    logic [LANES-1:0] lanes;
    logic             shift8;
  } rdCtl_t;

  typedef struct packed {
    logic [REG_CNT-1:0] sel;
    logic [LANES-1:0]   lanes;
    logic               shift8;
  } wrCtl_t;
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdRegA,
  input  logic [1:0]       rdSizeA,
  input  logic             rdHiA,
  input  logic [IDX_W-1:0] rdRegB,
  input  logic [1:0]       rdSizeB,
  input  logic             rdHiB,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrReg,
  input  logic [1:0]       wrSize,
  input  logic             wrHi,
  output rdCtl_t           rdCtlA,
  output rdCtl_t           rdCtlB,
  output wrCtl_t           wrCtl,
  output logic             rdBadA,
  output logic             rdBadB,
  output logic             wrBad
);
  localparam logic [LANES-1:0] LANE_ALL  = '1;
  localparam logic [LANES-1:0] LANE_WORD = LANES'(2'b11);
  localparam logic [LANES-1:0] LANE_LO   = LANES'(1'b1);

  function automatic logic isIllegal(logic [IDX_W-1:0] r, logic [1:0] sz);
    opSize_e s;
    s = opSize_e'(sz);
    return (s == SZ_RSVD) || (s == SZ_BYTE && int'(r) >= BYTE_REG_CNT);
  endfunction

  function automatic logic [LANES-1:0] sizeLanes(logic [1:0] sz);
    case (opSize_e'(sz))
      SZ_BYTE:  return LANE_LO;
      SZ_WORD:  return LANE_WORD;
      SZ_DWORD: return LANE_ALL;
      default:  return '0;
    endcase
  endfunction

  function automatic rdCtl_t decodeRead(logic [IDX_W-1:0] r, logic [1:0] sz, logic hi);
    rdCtl_t c;
    c.regIdx = r;
    c.shift8 = hi && (opSize_e'(sz) == SZ_BYTE);
    c.lanes  = isIllegal(r, sz) ? '0 : sizeLanes(sz);
    return c;
  endfunction

  logic wrIllegal;

  always_comb begin
    rdCtlA    = decodeRead(rdRegA, rdSizeA, rdHiA);
    rdCtlB    = decodeRead(rdRegB, rdSizeB, rdHiB);
    rdBadA    = isIllegal(rdRegA, rdSizeA);
    rdBadB    = isIllegal(rdRegB, rdSizeB);
    wrIllegal = isIllegal(wrReg, wrSize);
    wrBad     = wrEn && wrIllegal;
    wrCtl.shift8 = wrHi && (opSize_e'(wrSize) == SZ_BYTE);
    wrCtl.lanes  = sizeLanes(wrSize) << (wrCtl.shift8 ? 1 : 0);
    wrCtl.sel    = '0;
    if (wrEn && !wrIllegal) wrCtl.sel[wrReg] = 1'b1;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrCtl.sel)); // R2

  AST_BAD_NO_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    wrBad |-> (wrCtl.sel == '0)); // R7

  AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (wrCtl.sel == '0)); // R10
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rdCtl_t            rdCtlA,
  input  rdCtl_t            rdCtlB,
  input  wrCtl_t            wrCtl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  logic [REG_CNT-1:0][DATA_W-1:0] regs;
  logic [REG_CNT-1:0][DATA_W-1:0] touchMask;
  logic [DATA_W-1:0]              wrAligned;

  function automatic logic [DATA_W-1:0] laneBits(logic [LANES-1:0] lanes);
    logic [DATA_W-1:0] m;
    for (int l = 0; l < LANES; l++) m[l*8 +: 8] = {8{lanes[l]}};
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] readSlice(logic [DATA_W-1:0] raw, rdCtl_t c);
    logic [DATA_W-1:0] s;
    s = c.shift8 ? (raw >> 8) : raw;
    return s & laneBits(c.lanes);
  endfunction

  assign wrAligned = wrCtl.shift8 ? (wrData << 8) : wrData;

  for (genvar r = 0; r < REG_CNT; r++) begin : g_mask
    assign touchMask[r] = wrCtl.sel[r] ? laneBits(wrCtl.lanes) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regs <= '0;
    end else begin
      for (int r = 0; r < REG_CNT; r++)
        regs[r] <= (regs[r] & ~touchMask[r]) | (wrAligned & touchMask[r]);
    end
  end

  assign rdDataA = readSlice(regs[rdCtlA.regIdx], rdCtlA);
  assign rdDataB = readSlice(regs[rdCtlB.regIdx], rdCtlB);

  AST_SLICE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    ((regs & ~$past(touchMask)) == ($past(regs) & ~$past(touchMask)))); // R4

  AST_SLICE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (|wrCtl.sel) |=> ((regs & $past(touchMask)) ==
                      ({REG_CNT{$past(wrAligned)}} & $past(touchMask)))); // R6
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import rf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  rdRegA,
  input  logic [1:0]        rdSizeA,
  input  logic              rdHiA,
  output logic [DATA_W-1:0] rdDataA,
  output logic              rdBadA,
  input  logic [IDX_W-1:0]  rdRegB,
  input  logic [1:0]        rdSizeB,
  input  logic              rdHiB,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdBadB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrReg,
  input  logic [1:0]        wrSize,
  input  logic              wrHi,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrBad
);
  rdCtl_t rdCtlA, rdCtlB;
  wrCtl_t wrCtl;

  rf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .rdRegA(rdRegA), .rdSizeA(rdSizeA), .rdHiA(rdHiA),
    .rdRegB(rdRegB), .rdSizeB(rdSizeB), .rdHiB(rdHiB),
    .wrEn(wrEn), .wrReg(wrReg), .wrSize(wrSize), .wrHi(wrHi),
    .rdCtlA(rdCtlA), .rdCtlB(rdCtlB), .wrCtl(wrCtl),
    .rdBadA(rdBadA), .rdBadB(rdBadB), .wrBad(wrBad)
  );

  rf_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .rdCtlA(rdCtlA), .rdCtlB(rdCtlB), .wrCtl(wrCtl), .wrData(wrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

  AST_BAD_READ_ZERO_A: assert property (@(posedge clk) disable iff (!rstN)
    rdBadA |-> (rdDataA == '0)); // R7

  AST_BAD_READ_ZERO_B: assert property (@(posedge clk) disable iff (!rstN)
    rdBadB |-> (rdDataB == '0)); // R7

  AST_BYTE_READ_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    (rdSizeA == 2'b00) |-> (rdDataA[DATA_W-1:8] == '0)); // R3
endmodule

// File: tb/tb_alias_regfile.sv
module tb_alias_regfile;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] rdRegA = '0, rdRegB = '0, wrReg = '0;
  logic [1:0] rdSizeA = 2'b10, rdSizeB = 2'b10, wrSize = 2'b10;
  logic rdHiA = 1'b0, rdHiB = 1'b0, wrHi = 1'b0, wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdDataA, rdDataB;
  logic rdBadA, rdBadB, wrBad;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alias_regfile dut (.*);

  typedef struct packed {
    logic [23:0] tag;
    logic        wEn;
    logic [2:0]  wReg;
    logic [1:0]  wSz;
    logic        wHi;
    logic [31:0] wDat;
    logic [2:0]  rReg;
    logic [1:0]  rSz;
    logic        rHi;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{"R6 ", 1'b1, 3'd0, 2'b10, 1'b0, 32'h11223344, 3'd0, 2'b10, 1'b0, 32'h11223344},
    '{"R4 ", 1'b1, 3'd0, 2'b00, 1'b1, 32'h000000AB, 3'd0, 2'b10, 1'b0, 32'h1122AB44},
    '{"R4 ", 1'b1, 3'd0, 2'b00, 1'b0, 32'hFFFFFFCD, 3'd0, 2'b10, 1'b0, 32'h1122ABCD},
    '{"R5 ", 1'b1, 3'd0, 2'b01, 1'b0, 32'hAAAA5566, 3'd0, 2'b10, 1'b0, 32'h11225566},
    '{"R3 ", 1'b1, 3'd3, 2'b10, 1'b0, 32'hDEADBEEF, 3'd3, 2'b00, 1'b1, 32'h000000BE},
    '{"R10", 1'b0, 3'd3, 2'b10, 1'b0, 32'h00000000, 3'd3, 2'b01, 1'b0, 32'h0000BEEF},
    '{"R5 ", 1'b1, 3'd4, 2'b01, 1'b0, 32'h77771234, 3'd4, 2'b10, 1'b0, 32'h00001234},
    '{"R7 ", 1'b1, 3'd5, 2'b00, 1'b0, 32'h000000FF, 3'd5, 2'b10, 1'b0, 32'h00000000},
    '{"R2 ", 1'b1, 3'd7, 2'b10, 1'b0, 32'hCAFEF00D, 3'd7, 2'b01, 1'b0, 32'h0000F00D},
    '{"R7 ", 1'b1, 3'd2, 2'b11, 1'b0, 32'hFFFFFFFF, 3'd2, 2'b10, 1'b0, 32'h00000000},
    '{"R3 ", 1'b1, 3'd1, 2'b00, 1'b0, 32'h0000007F, 3'd1, 2'b00, 1'b0, 32'h0000007F}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(logic [2:0] r, logic [1:0] sz, logic hi, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrReg = r; wrSize = sz; wrHi = hi; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readA(logic [2:0] r, logic [1:0] sz, logic hi);
    rdRegA = r; rdSizeA = sz; rdHiA = hi;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] sum;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state on both ports
    for (int r = 0; r < 8; r++) begin
      rdRegB = 3'(r); rdSizeB = 2'b10;
      readA(3'(r), 2'b10, 1'b0);
      check("R1 port A", rdDataA, 32'h0);
      check("R1 port B", rdDataB, 32'h0);
    end

    // table of write-then-read vectors
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wrEn = VECS[i].wEn; wrReg = VECS[i].wReg; wrSize = VECS[i].wSz;
      wrHi = VECS[i].wHi; wrData = VECS[i].wDat;
      @(posedge clk);
      @(negedge clk);
      wrEn = 1'b0;
      readA(VECS[i].rReg, VECS[i].rSz, VECS[i].rHi);
      check($sformatf("%s vec %0d", VECS[i].tag, i), rdDataA, VECS[i].exp);
    end

    // R3: low byte and 16-bit views of the dword register
    readA(3'd0, 2'b00, 1'b0);
    check("R3 low byte", rdDataA, 32'h00000066);
    readA(3'd0, 2'b01, 1'b0);
    check("R3 word", rdDataA, 32'h00005566);

    // R8: same-cycle read returns old value
    @(negedge clk);
    readA(3'd0, 2'b10, 1'b0);
    wrEn = 1'b1; wrReg = 3'd0; wrSize = 2'b10; wrHi = 1'b0; wrData = 32'h00000099;
    #1;
    check("R8 old value", rdDataA, 32'h11225566);
    @(posedge clk);
    #1;
    check("R8 new value", rdDataA, 32'h00000099);
    @(negedge clk);
    wrEn = 1'b0;

    // R9: move a high byte from d to b via port B
    @(negedge clk);
    rdRegB = 3'd3; rdSizeB = 2'b00; rdHiB = 1'b1;
    #1;
    check("R9 move source", rdDataB, 32'h000000BE);
    wrEn = 1'b1; wrReg = 3'd1; wrSize = 2'b00; wrHi = 1'b1; wrData = rdDataB;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    readA(3'd1, 2'b10, 1'b0);
    check("R9 move result", rdDataA, 32'h0000BE7F);

    // R9: byte add, b.low += d.low, external adder
    readA(3'd1, 2'b00, 1'b0);
    rdRegB = 3'd3; rdSizeB = 2'b00; rdHiB = 1'b0;
    #1;
    sum = {1'b0, rdDataA[7:0]} + {1'b0, rdDataB[7:0]};
    doWrite(3'd1, 2'b00, 1'b0, {24'h0, sum[7:0]});
    readA(3'd1, 2'b10, 1'b0);
    check("R9 byte add", rdDataA, 32'h0000BE6E);

    // R9: byte subtract immediate 0x70
    readA(3'd1, 2'b00, 1'b0);
    doWrite(3'd1, 2'b00, 1'b0, {24'h0, rdDataA[7:0] - 8'h70});
    readA(3'd1, 2'b10, 1'b0);
    check("R9 byte sub imm", rdDataA, 32'h0000BEFE);

    // R7: illegal flags
    readA(3'd6, 2'b00, 1'b0);
    check("R7 rdBadA byte of index", {31'h0, rdBadA}, 32'h1);
    check("R7 illegal read zero", rdDataA, 32'h0);
    readA(3'd0, 2'b11, 1'b0);
    check("R7 rdBadA reserved size", {31'h0, rdBadA}, 32'h1);
    readA(3'd6, 2'b01, 1'b0);
    check("R7 rdBadA word of index", {31'h0, rdBadA}, 32'h0);
    rdRegB = 3'd4; rdSizeB = 2'b00; rdHiB = 1'b1;
    #1;
    check("R7 rdBadB byte of sp", {31'h0, rdBadB}, 32'h1);
    @(negedge clk);
    wrReg = 3'd5; wrSize = 2'b00; wrHi = 1'b1; wrEn = 1'b1;
    #1;
    check("R7 wrBad raised", {31'h0, wrBad}, 32'h1);
    wrEn = 1'b0;
    #1;
    check("R7 wrBad needs wrEn", {31'h0, wrBad}, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule